// File: doc/BRIEF.md
# Serial Link Low-Power State Sequencer

This block steps the low-power line states of a high-speed serial transmitter with one clock pair and one data pair. It moves the transmitter between standby and streaming. In standby every line is held low. When streaming is requested in serial mode, the block waits for the PLL and the driver bias. It then signals a wake-up from ultra-low-power, then the stop state, and then lets the packet engine take the lines for high-speed bursts. Each burst starts from the stop state and returns to it.

Two delays are programmable. One is a wake-up count spent in the wake-up state. The other is a pre-stream count, taken from the integration time, to which a fixed overhead is added before the first burst. A mode guard makes sure the parallel output and the serial link are never enabled together. The output mode can change only while the sequencer is idle in standby with no stream request. When the stream request is withdrawn, any burst in progress finishes first. Loss of PLL lock during a burst aborts it to the stop state.

Top module: `link_pwr_seq`

## Requirements
- R1: After reset and whenever the serial side is inactive (`ser_act_o` low), every line code is 2'b00 and `hs_en_o` is low.
- R2: From standby, the lines change to the wake-up code 2'b10 one cycle after a cycle in which `stream_req_i`, the latched serial mode, `pll_lock_i` and `bias_ok_i` are all high. If any of them is low, the block stays in standby.
- R3: The wake-up code 2'b10 is held for exactly `wake_dly_i`+1 cycles. A count of zero gives a single cycle.
- R4: After wake-up, the stop code 2'b11 is held for exactly `pre_dly_i`+OVH_CYC+1 cycles (OVH_CYC defaults to 4). At the end of that time the block enters high speed if `pkt_req_i` and `pll_lock_i` are high, and otherwise waits in the stop state.
- R5: `par_en_o` and `ser_act_o` are never high together. `ser_mode_i` (1 = serial, 0 = parallel) is latched only in standby while `stream_req_i` is low, and a change at any other time has no effect. `par_en_o` equals `stream_req_i` while parallel mode is latched.
- R6: In high speed, `hs_en_o` is high and every line code reads 2'b00. A `pkt_end_i` pulse returns the lines to 2'b11 on the next cycle. From the stop state, `pkt_req_i` together with PLL lock re-enters high speed on the next cycle.
- R7: A dropped stream request does not cut a burst short: high speed continues until `pkt_end_i`. The lines then show 2'b11 for one cycle and 2'b00 after that. A drop during wake-up gives one cycle of 2'b11 and then 2'b00. A drop in the stop state gives 2'b00 on the next cycle.
- R8: If PLL lock is lost during high speed, the next cycle shows 2'b11 with `hs_en_o` low. The block stays in the stop state until lock returns.
- R9: Pair p occupies `lp_lines_o[2p+1:2p]`, with bit 1 the positive line and bit 0 the negative line. Pair 0 is the clock pair and pair 1 is the data pair, and all pairs carry the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stream_req_i | input | 1 | Request to stream |
| ser_mode_i | input | 1 | Output mode select, 1 = serial, 0 = parallel |
| pll_lock_i | input | 1 | PLL locked |
| bias_ok_i | input | 1 | Driver bias stable |
| wake_dly_i | input | DLY_W | Wake-up delay count |
| pre_dly_i | input | DLY_W | Pre-stream (integration time) delay count |
| pkt_req_i | input | 1 | Packet engine has a packet ready |
| pkt_end_i | input | 1 | Packet engine finished the current packet |
| lp_lines_o | output | 2*PAIRS | Low-power line code per pair |
| hs_en_o | output | 1 | High-speed enable for the packet engine |
| ser_act_o | output | 1 | Serial link out of standby |
| par_en_o | output | 1 | Parallel output enable |

## Verification
Every state change lands on the first clock edge after the input that causes it. The line codes, `hs_en_o` and `ser_act_o` are decoded directly from the state register, so they show the new value one cycle after the stimulus. `par_en_o` follows `stream_req_i` in the same cycle. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the following edge, so each check reads the state one edge after its cause. Wake-up and pre-stream durations are counted sample by sample and compared with `wake_dly_i`+1 and `pre_dly_i`+OVH_CYC+1 over a grid of delay settings.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;
  typedef enum logic [2:0] {
    ST_STBY,
    ST_EXIT,
    ST_PRE,
    ST_STOP,
    ST_HS
  } lps_state_e;

  localparam logic [1:0] LP_00 = 2'b00;
  localparam logic [1:0] LP_10 = 2'b10;
  localparam logic [1:0] LP_11 = 2'b11;
endpackage

// File: rtl/lps_delay_cnt.sv
module lps_delay_cnt #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lps_mode_guard.sv
module lps_mode_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_stby_i,
  input  logic stream_req_i,
  input  logic ser_mode_i,
  output logic ser_mode_o,
  output logic par_en_o
);
  logic ser_mode_q;

  // mode may only change while idle in standby
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ser_mode_q <= 1'b0;
    else if (in_stby_i && !stream_req_i) ser_mode_q <= ser_mode_i;
  end

  assign ser_mode_o = ser_mode_q;
  assign par_en_o   = stream_req_i && !ser_mode_q;
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import link_pwr_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int OVH_CYC = 4,
  localparam int CW     = DLY_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stream_req_i,
  input  logic             ser_mode_i,
  input  logic             pll_lock_i,
  input  logic             bias_ok_i,
  input  logic             pkt_req_i,
  input  logic             pkt_end_i,
  input  logic [DLY_W-1:0] wake_dly_i,
  input  logic [DLY_W-1:0] pre_dly_i,
  input  logic             dly_zero_i,
  output logic             ld_o,
  output logic [CW-1:0]    ld_val_o,
  output lps_state_e       state_o
);
  lps_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    ld_o     = 1'b0;
    ld_val_o = CW'(wake_dly_i);
    unique case (state_q)
      ST_STBY: if (stream_req_i && ser_mode_i && pll_lock_i && bias_ok_i) begin
        state_d = ST_EXIT;
        ld_o    = 1'b1;
      end
      ST_EXIT: begin
        if (!stream_req_i) state_d = ST_STOP;
        else if (dly_zero_i) begin
          state_d  = ST_PRE;
          ld_o     = 1'b1;
          ld_val_o = CW'(pre_dly_i) + CW'(OVH_CYC);
        end
      end
      ST_PRE: begin
        if (!stream_req_i) state_d = ST_STBY;
        else if (dly_zero_i)
          state_d = (pkt_req_i && pll_lock_i) ? ST_HS : ST_STOP;
      end
      ST_STOP: begin
        if (!stream_req_i)                state_d = ST_STBY;
        else if (pkt_req_i && pll_lock_i) state_d = ST_HS;
      end
      ST_HS: begin
        // lock loss aborts; otherwise the packet always completes
        if (!pll_lock_i || pkt_end_i) state_d = ST_STOP;
      end
      default: state_d = ST_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STBY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
  import link_pwr_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int OVH_CYC = 4,
  parameter int PAIRS   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stream_req_i,
  input  logic               ser_mode_i,
  input  logic               pll_lock_i,
  input  logic               bias_ok_i,
  input  logic [DLY_W-1:0]   wake_dly_i,
  input  logic [DLY_W-1:0]   pre_dly_i,
  input  logic               pkt_req_i,
  input  logic               pkt_end_i,
  output logic [2*PAIRS-1:0] lp_lines_o,
  output logic               hs_en_o,
  output logic               ser_act_o,
  output logic               par_en_o
);
  localparam int CW = DLY_W + 1;

  lps_state_e    state;
  logic          ser_mode;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          dly_zero;
  logic [1:0]    code;

  lps_mode_guard u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_stby_i    (state == ST_STBY),
    .stream_req_i (stream_req_i),
    .ser_mode_i   (ser_mode_i),
    .ser_mode_o   (ser_mode),
    .par_en_o     (par_en_o)
  );

  lps_fsm #(.DLY_W(DLY_W), .OVH_CYC(OVH_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stream_req_i (stream_req_i),
    .ser_mode_i   (ser_mode),
    .pll_lock_i   (pll_lock_i),
    .bias_ok_i    (bias_ok_i),
    .pkt_req_i    (pkt_req_i),
    .pkt_end_i    (pkt_end_i),
    .wake_dly_i   (wake_dly_i),
    .pre_dly_i    (pre_dly_i),
    .dly_zero_i   (dly_zero),
    .ld_o         (ld),
    .ld_val_o     (ld_val),
    .state_o      (state)
  );

  lps_delay_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (dly_zero)
  );

  always_comb begin
    unique case (state)
      ST_EXIT:         code = LP_10;
      ST_PRE, ST_STOP: code = LP_11;
      default:         code = LP_00;
    endcase
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign lp_lines_o[2*p +: 2] = code;
  end

  assign hs_en_o   = (state == ST_HS);
  assign ser_act_o = (state != ST_STBY);
endmodule

// File: rtl/link_pwr_seq_chk.sv
module link_pwr_seq_chk #(
  parameter int PAIRS = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stream_req_i,
  input logic               pll_lock_i,
  input logic               bias_ok_i,
  input logic               pkt_end_i,
  input logic [2*PAIRS-1:0] lp_lines_o,
  input logic               hs_en_o,
  input logic               ser_act_o,
  input logic               par_en_o
);
  // R1
  stby_lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_act_o |-> (lp_lines_o == '0 && !hs_en_o));

  // R2
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_lines_o[1:0] == 2'b10 && $past(!ser_act_o))
      |-> $past(stream_req_i && pll_lock_i && bias_ok_i));

  // R5
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(par_en_o && ser_act_o));

  // R6
  hs_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> lp_lines_o == '0);

  // R7
  hs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o && pll_lock_i && !pkt_end_i) |=> hs_en_o);

  // R8
  lock_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o && !pll_lock_i) |=> (!hs_en_o && lp_lines_o[1:0] == 2'b11));

  for (genvar p = 1; p < PAIRS; p++) begin : g_same
    // R9
    pair_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lp_lines_o[2*p +: 2] == lp_lines_o[1:0]);
  end
endmodule

bind link_pwr_seq link_pwr_seq_chk #(.PAIRS(PAIRS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stream_req_i (stream_req_i),
  .pll_lock_i   (pll_lock_i),
  .bias_ok_i    (bias_ok_i),
  .pkt_end_i    (pkt_end_i),
  .lp_lines_o   (lp_lines_o),
  .hs_en_o      (hs_en_o),
  .ser_act_o    (ser_act_o),
  .par_en_o     (par_en_o)
);

// File: tb/tb_link_pwr_seq.sv
`timescale 1ns/1ps
module tb_link_pwr_seq;
  localparam int DLY_W = 8;
  localparam int OVH   = 4;
  localparam int PAIRS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stream_req_i = 1'b0, ser_mode_i = 1'b0, pll_lock_i = 1'b1, bias_ok_i = 1'b1;
  logic pkt_req_i = 1'b0, pkt_end_i = 1'b0;
  logic [DLY_W-1:0] wake_dly_i = '0, pre_dly_i = '0;
  logic [2*PAIRS-1:0] lp_lines_o;
  logic hs_en_o, ser_act_o, par_en_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  link_pwr_seq #(.DLY_W(DLY_W), .OVH_CYC(OVH), .PAIRS(PAIRS)) dut (
    .clk_i, .rst_ni, .stream_req_i, .ser_mode_i, .pll_lock_i, .bias_ok_i,
    .wake_dly_i, .pre_dly_i, .pkt_req_i, .pkt_end_i,
    .lp_lines_o, .hs_en_o, .ser_act_o, .par_en_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go_hs();
    for (int i = 0; i < 200 && !hs_en_o; i++) step();
  endtask

  task automatic close_burst();
    stream_req_i = 1'b0; pkt_req_i = 1'b0; pkt_end_i = 1'b1;
    step();
    pkt_end_i = 1'b0;
    step();
  endtask

  task automatic sweep(input int w, input int p);
    int n10, n11;
    n10 = 0; n11 = 0;
    wake_dly_i = DLY_W'(w); pre_dly_i = DLY_W'(p);
    pkt_req_i = 1'b1; stream_req_i = 1'b1;
    for (int i = 0; i < 400; i++) begin
      step();
      if (hs_en_o) break;
      if (lp_lines_o == 4'b1010) n10++;
      else if (lp_lines_o == 4'b1111) n11++;
    end
    chk("R3", $sformatf("wake cycles w=%0d", w), n10, w + 1);
    chk("R4", $sformatf("pre cycles p=%0d", p), n11, p + OVH + 1);
    chk("R6", "hs lines low", int'(lp_lines_o), 0);
    pkt_req_i = 1'b0; pkt_end_i = 1'b1;
    step();
    pkt_end_i = 1'b0;
    chk("R6", "stop after packet end", int'(lp_lines_o), 4'b1111);
    chk("R6", "hs off after end", int'(hs_en_o), 0);
    stream_req_i = 1'b0;
    step();
    chk("R7", "standby after drop in stop", int'(lp_lines_o), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    #1;
    chk("R1", "reset lines", int'(lp_lines_o), 0);
    chk("R1", "reset hs", int'(hs_en_o), 0);
    chk("R5", "reset par_en", int'(par_en_o), 0);
    step(); rst_ni = 1'b1;
    ser_mode_i = 1'b1;
    step(); step();

    // R3 R4 sweep over delay grid
    for (int w = 0; w < 4; w++)
      for (int p = 0; p < 6; p += 2)
        sweep(w, p);

    // R2 gating
    wake_dly_i = '0; pre_dly_i = '0;
    stream_req_i = 1'b1; pll_lock_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R2", "held without lock", int'(lp_lines_o), 0);
    end
    pll_lock_i = 1'b1; bias_ok_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R2", "held without bias", int'(lp_lines_o), 0);
    end
    bias_ok_i = 1'b1;
    step();
    chk("R2", "wake after gates", int'(lp_lines_o), 4'b1010);
    chk("R9", "pair fields", int'(lp_lines_o[3:2]), 2);
    // R7 drop during wake-up
    stream_req_i = 1'b0;
    step(); chk("R7", "stop after wake drop", int'(lp_lines_o), 4'b1111);
    step(); chk("R7", "standby after stop", int'(lp_lines_o), 0);

    // R7 drop during burst
    stream_req_i = 1'b1; pkt_req_i = 1'b1;
    go_hs();
    chk("R6", "burst entered", int'(hs_en_o), 1);
    stream_req_i = 1'b0; pkt_req_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R7", "burst continues", int'(hs_en_o), 1);
    end
    pkt_end_i = 1'b1;
    step(); pkt_end_i = 1'b0;
    chk("R7", "stop after burst", int'(lp_lines_o), 4'b1111);
    step(); chk("R7", "standby after burst", int'(lp_lines_o), 0);

    // R8 lock loss in burst
    stream_req_i = 1'b1; pkt_req_i = 1'b1;
    go_hs();
    pll_lock_i = 1'b0;
    step();
    chk("R8", "abort lines", int'(lp_lines_o), 4'b1111);
    chk("R8", "abort hs", int'(hs_en_o), 0);
    for (int i = 0; i < 2; i++) begin
      step(); chk("R8", "wait for lock", int'(hs_en_o), 0);
    end
    pll_lock_i = 1'b1;
    step(); chk("R6", "re-enter from stop", int'(hs_en_o), 1);
    close_burst();
    chk("R1", "standby after close", int'(ser_act_o), 0);

    // R5 mode exclusivity
    ser_mode_i = 1'b0;
    step();
    stream_req_i = 1'b1;
    step();
    chk("R5", "par enabled", int'(par_en_o), 1);
    chk("R5", "serial idle", int'(ser_act_o), 0);
    ser_mode_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R5", "mode change ignored par", int'(par_en_o), 1);
      chk("R5", "mode change ignored lines", int'(lp_lines_o), 0);
    end
    stream_req_i = 1'b0;
    step(); chk("R5", "par off", int'(par_en_o), 0);
    stream_req_i = 1'b1;
    step();
    chk("R5", "serial wakes", int'(lp_lines_o), 4'b1010);
    chk("R5", "par off in serial", int'(par_en_o), 0);
    stream_req_i = 1'b0;
    step(); step();
    chk("R1", "final standby", int'(lp_lines_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule